// File: doc/BRIEF.md
# Character Video RAM with ANSI Terminal Mirror

This block is a 2 KB byte-wide character video memory that sits on a simple processor bus and, alongside the memory, turns every visible character write into ANSI terminal bytes for a remote text screen. The memory answers reads with the byte last stored at that offset. A write that lands in the 80 by 24 text area also queues the escape bytes needed to show the character on a terminal: a reverse-video on/off code when the attribute changes, a cursor-position code when the cell does not directly follow the previous one, and then the character glyph.

The window is chosen by a single compare of the upper address bits against an aligned base address. A nonzero bank-select input hides the window completely. The terminal bytes leave over a valid/ready stream. While bytes from an earlier write are still queued, a new write is held off with a wait signal, so writes are never dropped or reordered.

Top module: `vram_ansi_mirror`

## Requirements
- R1: A read with `acc_en`=1 and `acc_we`=0 to an address whose bits above bit 10 equal those of `BASE_ADDR`, with `bank_sel`=0, returns the byte last written at offset `acc_addr[10:0]` on `acc_rdata` one clock after the access.
- R2: A read to an address outside the 2048-byte window returns 8'hFF on `acc_rdata` one clock later.
- R3: When `bank_sel` is nonzero, reads return 8'hFF, and writes neither change the memory nor produce any terminal byte.
- R4: A write at offset 1920 to 2047 updates the memory and produces no terminal byte.
- R5: A write to a visible offset o (0 to 1919) whose cell does not directly follow the previous emitted cell sends ESC (8'h1B), '[', the row, ';', the column, 'H' and then the glyph, with row = o/80+1 and column = o%80+1, each in decimal ASCII without leading zeros.
- R6: If the cell has the same row as the previously emitted cell and a column exactly one larger, only the glyph byte is sent.
- R7: Bit 7 of the written byte selects reverse video. ESC "[07m" is sent ahead of the other bytes only when the attribute goes from normal to reverse, ESC "[00m" only when it goes from reverse to normal. The attribute is normal after reset.
- R8: The glyph is the low 7 bits of the written byte, except that codes below 8'h20 become 'O' (8'h4F) and code 8'h7F becomes 'X' (8'h58).
- R9: After reset `tx_valid`=0, `acc_wait`=0, `acc_rdata`=8'hFF, and the remembered last cell is row 0, column 0, so the first visible write always sends a position code.
- R10: While terminal bytes are queued (`tx_valid`=1), any write request raises `acc_wait` and is not taken; when the queue is empty `acc_wait` is 0 and the write is taken on that clock. Every taken write's bytes are sent in the order the writes were taken.
- R11: A byte is transferred when `tx_valid` and `tx_ready` are both 1 at a clock edge; while `tx_valid`=1 and `tx_ready`=0, `tx_valid` stays 1 and `tx_data` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Bus access request |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte address |
| acc_wdata | input | 8 | Write data |
| bank_sel | input | BANK_W | Bank select; nonzero hides the window |
| acc_rdata | output | 8 | Read data, valid one clock after a read |
| acc_wait | output | 1 | Write stall while terminal bytes are queued |
| tx_valid | output | 1 | Terminal byte available |
| tx_ready | input | 1 | Consumer accepts the terminal byte |
| tx_data | output | 8 | Terminal byte |

## Verification
The two functions that meet in one cycle are the terminal stream draining its last queued byte and a new write request arriving on the bus; the write must stay stalled until the very edge after the final handshake and then be taken with the cursor and attribute state left by the previous write. The bench provokes this by throttling `tx_ready` at random, by holding it low for several cycles while a write waits, and by random runs of consecutive offsets with mixed attribute bits. Each byte leaving the stream is compared in order against a queue built by an independent model that formats the escape text with string formatting, and the wait output is checked both while the stream is blocked and after it empties.

// File: rtl/vam_pkg.sv
`timescale 1ns/1ps
package vam_pkg;
  localparam int SEQ_MAX = 14;
  localparam int LEN_W   = $clog2(SEQ_MAX + 1);
  localparam int RC_W    = 7;

  localparam logic [7:0] CH_ESC  = 8'h1B;
  localparam logic [7:0] CH_LBR  = 8'h5B;
  localparam logic [7:0] CH_SEMI = 8'h3B;
  localparam logic [7:0] CH_H    = 8'h48;
  localparam logic [7:0] CH_M    = 8'h6D;
  localparam logic [7:0] CH_ZERO = 8'h30;
  localparam logic [7:0] CH_SEVN = 8'h37;
  localparam logic [7:0] CH_O    = 8'h4F;
  localparam logic [7:0] CH_X    = 8'h58;

  typedef struct packed {
    logic [SEQ_MAX-1:0][7:0] data;
    logic [LEN_W-1:0]        len;
  } seq_t;

  function automatic seq_t seq_add(input seq_t s, input logic [7:0] b);
    seq_t r;
    r = s;
    r.data[r.len] = b;
    r.len = r.len + 1'b1;
    return r;
  endfunction

  function automatic seq_t seq_add_num(input seq_t s, input logic [RC_W-1:0] v);
    seq_t r;
    logic [RC_W-1:0] tens;
    logic [RC_W-1:0] ones;
    tens = v / RC_W'(10);
    ones = v - tens * RC_W'(10);
    r = s;
    if (tens != '0) r = seq_add(r, CH_ZERO + {1'b0, tens});
    r = seq_add(r, CH_ZERO + {1'b0, ones});
    return r;
  endfunction

  function automatic logic [7:0] glyph_of(input logic [7:0] code);
    logic [7:0] low;
    low = {1'b0, code[6:0]};
    if (low < 8'h20)       return CH_O;
    else if (low == 8'h7F) return CH_X;
    else                   return low;
  endfunction
endpackage

// File: rtl/vam_store.sv
`timescale 1ns/1ps
module vam_store #(
  parameter int DEPTH = 2048,
  localparam int OFF_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             rd_hit,
  input  logic [OFF_W-1:0] off,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata
);
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[off] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= 8'hFF;
    else if (rd_en) rdata <= rd_hit ? cells[off] : 8'hFF;
  end
endmodule

// File: rtl/vam_compose.sv
`timescale 1ns/1ps
module vam_compose
  import vam_pkg::*;
#(
  parameter int COLS  = 80,
  parameter int OFF_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic [OFF_W-1:0] off,
  input  logic [7:0]       code,
  output seq_t             seq
);
  localparam logic [OFF_W-1:0] COLS_V = OFF_W'(COLS);

  function automatic logic [RC_W-1:0] row_of(input logic [OFF_W-1:0] o);
    return RC_W'(o / COLS_V) + RC_W'(1);
  endfunction

  function automatic logic [RC_W-1:0] col_of(input logic [OFF_W-1:0] o);
    return RC_W'(o % COLS_V) + RC_W'(1);
  endfunction

  logic            attr_q;
  logic [RC_W-1:0] last_row_q;
  logic [RC_W-1:0] last_col_q;
  logic [RC_W-1:0] row_n;
  logic [RC_W-1:0] col_n;
  logic            rev_n;
  logic            follows;

  assign row_n   = row_of(off);
  assign col_n   = col_of(off);
  assign rev_n   = code[7];
  assign follows = (row_n == last_row_q) && (col_n == last_col_q + RC_W'(1));

  always_comb begin
    seq = '0;
    if (rev_n && !attr_q) begin
      seq = seq_add(seq, CH_ESC);
      seq = seq_add(seq, CH_LBR);
      seq = seq_add(seq, CH_ZERO);
      seq = seq_add(seq, CH_SEVN);
      seq = seq_add(seq, CH_M);
    end else if (!rev_n && attr_q) begin
      seq = seq_add(seq, CH_ESC);
      seq = seq_add(seq, CH_LBR);
      seq = seq_add(seq, CH_ZERO);
      seq = seq_add(seq, CH_ZERO);
      seq = seq_add(seq, CH_M);
    end
    if (!follows) begin
      seq = seq_add(seq, CH_ESC);
      seq = seq_add(seq, CH_LBR);
      seq = seq_add_num(seq, row_n);
      seq = seq_add(seq, CH_SEMI);
      seq = seq_add_num(seq, col_n);
      seq = seq_add(seq, CH_H);
    end
    seq = seq_add(seq, glyph_of(code));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      attr_q     <= 1'b0;
      last_row_q <= '0;
      last_col_q <= '0;
    end else if (upd) begin
      attr_q     <= rev_n;
      last_row_q <= row_n;
      last_col_q <= col_n;
    end
  end
endmodule

// File: rtl/vam_emitter.sv
`timescale 1ns/1ps
module vam_emitter
  import vam_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  seq_t       seq_in,
  output logic       busy,
  output logic       tx_valid,
  input  logic       tx_ready,
  output logic [7:0] tx_data
);
  logic [SEQ_MAX-1:0][7:0] pend_q;
  logic [LEN_W-1:0]        cnt_q;
  logic                    hand;

  assign busy     = (cnt_q != '0);
  assign tx_valid = busy;
  assign tx_data  = pend_q[0];
  assign hand     = busy && tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      pend_q <= seq_in.data;
      cnt_q  <= seq_in.len;
    end else if (hand) begin
      pend_q <= {8'h00, pend_q[SEQ_MAX-1:1]};
      cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/vram_ansi_mirror.sv
`timescale 1ns/1ps
module vram_ansi_mirror
  import vam_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                WIN_BYTES = 2048,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h8000,
  parameter int                COLS      = 80,
  parameter int                ROWS      = 24,
  parameter int                BANK_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [7:0]        acc_wdata,
  input  logic [BANK_W-1:0] bank_sel,
  output logic [7:0]        acc_rdata,
  output logic              acc_wait,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data
);
  localparam int               OFF_W     = $clog2(WIN_BYTES);
  localparam int               TAG_W     = ADDR_W - OFF_W;
  localparam logic [TAG_W-1:0] BASE_TAG  = BASE_ADDR[ADDR_W-1:OFF_W];
  localparam logic [OFF_W-1:0] VIS_LIMIT = OFF_W'(COLS * ROWS);

  logic             win_hit;
  logic             bank_open;
  logic [OFF_W-1:0] cell_off;
  logic             rd_evt;
  logic             wr_req;
  logic             wr_take;
  logic             visible;
  logic             emit_go;
  logic             busy;
  seq_t             seq_w;

  assign win_hit   = (acc_addr[ADDR_W-1:OFF_W] == BASE_TAG);
  assign bank_open = (bank_sel == '0);
  assign cell_off  = acc_addr[OFF_W-1:0];
  assign rd_evt    = acc_en && !acc_we;
  assign wr_req    = acc_en && acc_we;
  assign acc_wait  = wr_req && busy;
  assign wr_take   = wr_req && !busy && win_hit && bank_open;
  assign visible   = (cell_off < VIS_LIMIT);
  assign emit_go   = wr_take && visible;

  vam_store #(.DEPTH(WIN_BYTES)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_take),
    .rd_en  (rd_evt),
    .rd_hit (win_hit && bank_open),
    .off    (cell_off),
    .wdata  (acc_wdata),
    .rdata  (acc_rdata)
  );

  vam_compose #(.COLS(COLS), .OFF_W(OFF_W)) u_compose (
    .clk   (clk),
    .rst_n (rst_n),
    .upd   (emit_go),
    .off   (cell_off),
    .code  (acc_wdata),
    .seq   (seq_w)
  );

  vam_emitter u_emit (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (emit_go),
    .seq_in   (seq_w),
    .busy     (busy),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_data  (tx_data)
  );
endmodule

// File: rtl/vam_checker.sv
`timescale 1ns/1ps
module vam_checker #(
  parameter int                ADDR_W    = 16,
  parameter int                WIN_BYTES = 2048,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h8000,
  parameter int                COLS      = 80,
  parameter int                ROWS      = 24,
  parameter int                BANK_W    = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_en,
  input logic              acc_we,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [BANK_W-1:0] bank_sel,
  input logic [7:0]        acc_rdata,
  input logic              acc_wait,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_data
);
  localparam int               OFF_W = $clog2(WIN_BYTES);
  localparam logic [OFF_W-1:0] VIS   = OFF_W'(COLS * ROWS);

  logic in_win;
  logic shown_cell;
  assign in_win     = (acc_addr[ADDR_W-1:OFF_W] == BASE_ADDR[ADDR_W-1:OFF_W]);
  assign shown_cell = (acc_addr[OFF_W-1:0] < VIS);

  // R11
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  // R10
  wait_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wait |-> tx_valid);

  // R10
  wait_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en && acc_we && !tx_valid |-> !acc_wait);

  // R2
  outside_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en && !acc_we && !in_win |=> acc_rdata == 8'hFF);

  // R3
  bank_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en && !acc_we && bank_sel != '0 |=> acc_rdata == 8'hFF);

  // R3
  bank_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en && acc_we && bank_sel != '0 && !tx_valid |=> !tx_valid);

  // R4
  hidden_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en && acc_we && in_win && bank_sel == '0 && !shown_cell && !tx_valid |=> !tx_valid);

  // R5
  visible_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en && acc_we && in_win && bank_sel == '0 && shown_cell && !tx_valid |=> tx_valid);
endmodule

bind vram_ansi_mirror vam_checker #(
  .ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES), .BASE_ADDR(BASE_ADDR),
  .COLS(COLS), .ROWS(ROWS), .BANK_W(BANK_W)
) u_vam_chk (
  .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we),
  .acc_addr(acc_addr), .bank_sel(bank_sel), .acc_rdata(acc_rdata),
  .acc_wait(acc_wait), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data)
);

// File: tb/test_vram_ansi_mirror.sv
`timescale 1ns/1ps
module test_vram_ansi_mirror;
  localparam logic [15:0] BASE = 16'h8000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_en = 1'b0;
  logic        acc_we = 1'b0;
  logic [15:0] acc_addr = '0;
  logic [7:0]  acc_wdata = '0;
  logic [1:0]  bank_sel = '0;
  logic [7:0]  acc_rdata;
  logic        acc_wait;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [7:0]  tx_data;

  always #2.5 clk = ~clk;

  vram_ansi_mirror i_vram_ansi_mirror (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .bank_sel(bank_sel),
    .acc_rdata(acc_rdata), .acc_wait(acc_wait), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic [7:0] mem_m [2048];
  bit         wr_m  [2048];
  logic [7:0] exp_q [$];
  bit         attr_m = 0;
  int         lrow_m = 0;
  int         lcol_m = 0;
  string      cur_tag = "R9";
  bit         hold_ready = 0;
  bit         hold_v = 0;
  logic [7:0] hold_d = '0;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] shown(input logic [7:0] v);
    int c;
    c = int'(v & 8'h7F);
    if (c < 32) return 8'h4F;
    if (c == 127) return 8'h58;
    return 8'(c);
  endfunction

  task automatic model_write(input logic [15:0] a, input logic [7:0] d, input logic [1:0] bk);
    int off, row, col;
    string s;
    if (a[15:11] != BASE[15:11] || bk != 2'd0) return;
    off = int'(a[10:0]);
    mem_m[off] = d;
    wr_m[off] = 1;
    if (off >= 1920) return;
    row = off / 80 + 1;
    col = off % 80 + 1;
    s = "";
    if (d[7] && !attr_m) s = $sformatf("%c[07m", 27);
    if (!d[7] && attr_m) s = $sformatf("%c[00m", 27);
    attr_m = d[7];
    if (!(row == lrow_m && col == lcol_m + 1))
      s = {s, $sformatf("%c[%0d;%0dH", 27, row, col)};
    s = {s, $sformatf("%c", shown(d))};
    lrow_m = row;
    lcol_m = col;
    for (int i = 0; i < s.len(); i++) exp_q.push_back(s[i]);
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input logic [1:0] bk);
    acc_en = 1; acc_we = 1; acc_addr = a; acc_wdata = d; bank_sel = bk;
    #1;
    while (acc_wait) begin
      @(negedge clk);
      #1;
    end
    model_write(a, d, bk);
    @(posedge clk);
    @(negedge clk);
    acc_en = 0; acc_we = 0; bank_sel = 0;
  endtask

  task automatic bus_read(input string tag, input logic [15:0] a, input logic [1:0] bk);
    logic [7:0] e;
    bit known;
    acc_en = 1; acc_we = 0; acc_addr = a; bank_sel = bk;
    known = 1;
    if (a[15:11] != BASE[15:11] || bk != 2'd0) e = 8'hFF;
    else if (wr_m[a[10:0]]) e = mem_m[a[10:0]];
    else begin e = 8'h00; known = 0; end
    @(posedge clk);
    @(negedge clk);
    if (known) check(tag, "read data", {24'h0, acc_rdata}, {24'h0, e});
    acc_en = 0; bank_sel = 0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || tx_valid) @(negedge clk);
    check(cur_tag, "bytes left in expected queue", exp_q.size(), 0);
  endtask

  // stream monitor and ready driver
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_v && tx_valid) check("R11", "held byte changed", {24'h0, tx_data}, {24'h0, hold_d});
      if (hold_v) check("R11", "valid dropped while stalled", {31'h0, tx_valid}, 32'd1);
      tx_ready = hold_ready ? 1'b0 : (($urandom % 4) != 0);
      hold_v = tx_valid && !tx_ready;
      hold_d = tx_data;
      if (tx_valid && tx_ready) begin
        if (exp_q.size() == 0) check(cur_tag, "unexpected byte", {24'h0, tx_data}, 32'hFFFF_FFFF);
        else check(cur_tag, "stream byte", {24'h0, tx_data}, {24'h0, exp_q.pop_front()});
      end
    end
  end

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        total++;
        bad++;
        $display("FAIL R10 watchdog actual=%0d expected<150000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    int prev;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    // R9 reset state
    check("R9", "tx_valid at reset", {31'h0, tx_valid}, 0);
    check("R9", "acc_wait at reset", {31'h0, acc_wait}, 0);
    check("R9", "rdata at reset", {24'h0, acc_rdata}, 32'hFF);
    rst_n = 1;
    @(negedge clk);

    cur_tag = "R9";  bus_write(BASE + 16'd0, 8'h41, 0); drain();
    cur_tag = "R6";  bus_write(BASE + 16'd1, 8'h42, 0); drain();
    cur_tag = "R5";  bus_write(BASE + 16'd1919, 8'h7A, 0); drain();
    cur_tag = "R5";  bus_write(BASE + 16'd85, 8'h33, 0); drain();
    cur_tag = "R7";  bus_write(BASE + 16'd86, 8'hC1, 0); drain();
    cur_tag = "R7";  bus_write(BASE + 16'd87, 8'hC2, 0); drain();
    cur_tag = "R7";  bus_write(BASE + 16'd88, 8'h43, 0); drain();
    cur_tag = "R8";  bus_write(BASE + 16'd89, 8'h05, 0); drain();
    cur_tag = "R8";  bus_write(BASE + 16'd90, 8'h7F, 0); drain();
    cur_tag = "R8";  bus_write(BASE + 16'd500, 8'hFF, 0); drain();

    // R4 hidden offset
    cur_tag = "R4";
    bus_write(BASE + 16'd2000, 8'h55, 0);
    check("R4", "stream after hidden write", {31'h0, tx_valid}, 0);
    bus_read("R1", BASE + 16'd2000, 0);
    bus_read("R1", BASE + 16'd0, 0);

    // R3 bank hidden
    cur_tag = "R3";
    bus_write(BASE + 16'd0, 8'h11, 2'd1);
    check("R3", "stream after banked write", {31'h0, tx_valid}, 0);
    bus_read("R3", BASE + 16'd0, 0);
    bus_read("R3", BASE + 16'd0, 2'd2);

    // R2 outside the window
    bus_read("R2", 16'h7FFF, 0);
    bus_read("R2", 16'h8800, 0);

    // R10 stall while stream is blocked
    cur_tag = "R10";
    hold_ready = 1;
    bus_write(BASE + 16'd200, 8'h71, 0);
    acc_en = 1; acc_we = 1; acc_addr = BASE + 16'd201; acc_wdata = 8'h72;
    #1;
    check("R10", "wait while bytes queued", {31'h0, acc_wait}, 1);
    repeat (3) @(negedge clk);
    #1;
    check("R10", "wait still held", {31'h0, acc_wait}, 1);
    hold_ready = 0;
    bus_write(BASE + 16'd201, 8'h72, 0);
    drain();
    acc_en = 1; acc_we = 1; acc_addr = BASE + 16'd300;
    #1;
    check("R10", "wait low when idle", {31'h0, acc_wait}, 0);
    acc_en = 0; acc_we = 0;
    @(negedge clk);

    // random mix
    cur_tag = "R11";
    prev = 0;
    for (int n = 0; n < 400; n++) begin
      int r, off;
      logic [15:0] a;
      logic [1:0] bk;
      r = int'($urandom % 10);
      if (r < 4) off = (prev + 1) % 2048;
      else off = int'($urandom % 2048);
      a = (r < 8) ? BASE + 16'(off) : 16'($urandom);
      bk = (($urandom % 10) == 0) ? 2'(1 + $urandom % 3) : 2'd0;
      if (($urandom % 10) < 7) begin
        bus_write(a, 8'($urandom), bk);
        prev = off;
      end else begin
        bus_read("R1", a, bk);
      end
    end
    drain();
    finish_run();
  end
endmodule